// File: doc/BRIEF.md
# Strap-Addressed Serial Register Write Target for a Three-Channel LED Dimmer

This block is the configuration port of a three-channel LED dimmer. It listens on a two-wire serial bus (I2C), answers to one of two unrelated 7-bit device addresses, and stores single-register writes in a small, sparse register file. The device address is chosen by a strap input. The register file holds one general-purpose byte, one time-step byte, and seven timing and level bytes per channel. The channel groups sit at separate high addresses.

SCL and SDA are sampled by the system clock through two-flop synchronizers. The system clock must run at least 8 times faster than SCL. START and STOP are detected on the synchronized lines. Bytes are shifted in with the most significant bit first. The target acknowledges by asking the pad to pull SDA low during the ninth clock.

A hardware-enable pin works as an asynchronous reset. Driving it low puts every register back to its power-on value, which turns the outputs off, and drops any frame in progress. The system reset `rst_n` has the same effect. Both resets are asserted asynchronously and released synchronously.

Top module: `ledctl_i2c_regs`

## Requirements
- R1: The target answers to device address 0x18 when `addr_sel` is 0 and to 0x67 when `addr_sel` is 1. A frame sent to any other address gets no acknowledge on any of its bytes and changes no register.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START opens a new frame exactly as a first START does. A STOP or START that arrives before the data byte is complete ends the frame with no write. Each byte is taken most significant bit first.
- R3: `sda_pull_low` is asserted only while SCL is low. It stays asserted through the ninth clock after each acknowledged byte: a matching write address, a register address, or a data byte. It is released after that ninth clock's falling edge.
- R4: A device-address byte with the direction bit (bit 0) at 1 is not acknowledged. The target then stays silent until the next START or STOP.
- R5: In a frame of device address (direction 0), register address and data byte, the data byte is stored in the register named by the register-address byte. Further data bytes in the same frame are acknowledged and overwrite that same register.
- R6: Register map and outputs. `gp_q` is address 0x10 and resets to 0x00. `step_q` is address 0x20 and resets to 0x88. Channel c (0 to 2) has upper address nibble 0xA+c. Its lower nibble selects a field: 9 high level, 8 low level, 1 delay, 5 rise dwell, 3 high time, 4 fall dwell, 2 low time. The two level fields reset to 0xE0 and the other five reset to 0x00. Field k of channel c appears on `ch_cfg[(c*7+k)*8 +: 8]`, with k = 0..6 in the order: high level, low level, delay, rise dwell, high time, fall dwell, low time.
- R7: A write to an address outside the map (any address not listed in R6) is still acknowledged on all three bytes and changes no register.
- R8: Driving `hw_en` low, or `rst_n` low, sets every register to its R6 default at once, with no clock edge needed. It also abandons any frame in progress, so a data byte that arrives after the reset is not acknowledged and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low system reset, asynchronous assert |
| hw_en | input | 1 | Hardware enable; low resets all registers and the bus logic |
| addr_sel | input | 1 | Address strap: 0 selects 0x18, 1 selects 0x67 |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | Request to the open-drain pad to pull SDA low |
| gp_q | output | 8 | General-purpose register (0x10) |
| step_q | output | 8 | Time-step register (0x20) |
| ch_cfg | output | 168 | Per-channel fields, packed as described in R6 |

## Verification
The assertions assume SCL and SDA follow the bus rules. SDA changes only while SCL is low, except at START and STOP, and each SCL level lasts many system clocks, so the synchronized copies never show a false START or a skipped edge. The stimulus builds every frame from one bit task. That task changes SDA a quarter period after SCL falls and holds each SCL level for 16 system clocks, which is well inside the 8x ratio. The bench models the wired-AND bus by combining the master's drive with `sda_pull_low`, so an acknowledge can only be seen where the pad could actually pull the line. Resets are applied only between complete bus bits, so a reset never lands in the middle of an SCL level that the checks depend on.

// File: rtl/ledctl_pkg.sv
package ledctl_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_FIELDS = 7;

  // Field index inside one channel group; also the slot order on ch_cfg.
  typedef enum logic [2:0] {
    F_HI_LVL  = 3'd0,
    F_LO_LVL  = 3'd1,
    F_DELAY   = 3'd2,
    F_RISE    = 3'd3,
    F_HI_TIME = 3'd4,
    F_FALL    = 3'd5,
    F_LO_TIME = 3'd6
  } field_e;

  typedef struct packed {
    logic   hit;
    field_e idx;
  } fsel_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_REG, ST_ACK_REG, ST_DATA, ST_ACK_DATA, ST_SKIP
  } rx_state_e;

  // Low address nibble to field slot; the offsets are decoded by the dimmer core.
  function automatic fsel_t field_of(input logic [3:0] off);
    fsel_t r;
    r.hit = 1'b1;
    case (off)
      4'h9:    r.idx = F_HI_LVL;
      4'h8:    r.idx = F_LO_LVL;
      4'h1:    r.idx = F_DELAY;
      4'h5:    r.idx = F_RISE;
      4'h3:    r.idx = F_HI_TIME;
      4'h4:    r.idx = F_FALL;
      4'h2:    r.idx = F_LO_TIME;
      default: begin r.hit = 1'b0; r.idx = F_HI_LVL; end
    endcase
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] field_reset(input field_e f);
    return (f == F_HI_LVL || f == F_LO_LVL) ? 8'hE0 : 8'h00;
  endfunction

endpackage

// File: rtl/ledctl_rst_sync.sv
module ledctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/ledctl_bus_sync.sv
module ledctl_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic              scl_d_q, sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
      sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
      scl_d_q    <= scl_pipe_q[STAGES-1];
      sda_d_q    <= sda_pipe_q[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  =  scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s &  scl_d_q;
  assign start_det =  scl_s &  scl_d_q &  sda_d_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_d_q & ~sda_d_q &  sda_s;
endmodule

// File: rtl/ledctl_i2c_rx.sv
module ledctl_i2c_rx
  import ledctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_LO = 7'h18,
  parameter logic [6:0] DEV_ADDR_HI = 7'h67
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_low,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  rx_state_e         state_q, state_d;
  logic [2:0]        cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [BYTE_W-1:0] sh_q, sh_d, ptr_q, ptr_d, wdat_q, wdat_d;
  logic              sda_low_q, sda_low_d, wr_en_q, wr_en_d;
  logic [6:0]        dev_addr;
  logic              shifting;

  assign dev_addr = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
  assign shifting = (state_q == ST_DEV) || (state_q == ST_REG) || (state_q == ST_DATA);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    full_d    = full_q;
    sh_d      = sh_q;
    ptr_d     = ptr_q;
    wdat_d    = wdat_q;
    sda_low_d = sda_low_q;
    wr_en_d   = 1'b0;
    if (start_det) begin
      state_d = ST_DEV; cnt_d = '0; full_d = 1'b0; sda_low_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE; cnt_d = '0; full_d = 1'b0; sda_low_d = 1'b0;
    end else if (scl_rise && shifting && !full_q) begin
      sh_d  = {sh_q[BYTE_W-2:0], sda_s};
      cnt_d = 3'(cnt_q + 3'd1);
      if (cnt_q == 3'd7) full_d = 1'b1;
    end else if (scl_fall) begin
      if (full_q) begin
        full_d = 1'b0;
        case (state_q)
          ST_DEV:
            if (sh_q[7:1] == dev_addr && !sh_q[0]) begin
              state_d = ST_ACK_DEV; sda_low_d = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          ST_REG:  begin ptr_d = sh_q; state_d = ST_ACK_REG; sda_low_d = 1'b1; end
          ST_DATA: begin wdat_d = sh_q; wr_en_d = 1'b1; state_d = ST_ACK_DATA; sda_low_d = 1'b1; end
          default: ;
        endcase
      end else begin
        case (state_q)
          ST_ACK_DEV:  begin state_d = ST_REG;  sda_low_d = 1'b0; end
          ST_ACK_REG:  begin state_d = ST_DATA; sda_low_d = 1'b0; end
          ST_ACK_DATA: begin state_d = ST_DATA; sda_low_d = 1'b0; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      full_q    <= 1'b0;
      sh_q      <= '0;
      ptr_q     <= '0;
      wdat_q    <= '0;
      sda_low_q <= 1'b0;
      wr_en_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      full_q    <= full_d;
      sh_q      <= sh_d;
      ptr_q     <= ptr_d;
      wdat_q    <= wdat_d;
      sda_low_q <= sda_low_d;
      wr_en_q   <= wr_en_d;
    end
  end

  assign sda_low = sda_low_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = ptr_q;
  assign wr_data = wdat_q;

  assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_q) |-> !scl_s);
  assert_stop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !sda_low_q));
  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_low_q);
  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (state_q == ST_ACK_DATA && sda_low_q));
endmodule

// File: rtl/ledctl_regfile.sv
module ledctl_regfile
  import ledctl_pkg::*;
#(
  parameter int unsigned       NUM_CH    = 3,
  parameter logic [3:0]        CH_BASE   = 4'hA,
  parameter logic [BYTE_W-1:0] GP_ADDR   = 8'h10,
  parameter logic [BYTE_W-1:0] STEP_ADDR = 8'h20,
  parameter logic [BYTE_W-1:0] GP_RST    = 8'h00,
  parameter logic [BYTE_W-1:0] STEP_RST  = 8'h88,
  localparam int unsigned      CFG_W     = NUM_CH * N_FIELDS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] gp_q,
  output logic [BYTE_W-1:0] step_q,
  output logic [CFG_W-1:0]  ch_cfg
);
  fsel_t      sel;
  logic [3:0] grp;
  logic       ch_hit, hit;

  assign sel    = field_of(wr_addr[3:0]);
  assign grp    = 4'(wr_addr[7:4] - CH_BASE);
  assign ch_hit = sel.hit && (wr_addr[7:4] >= CH_BASE) && (32'(grp) < NUM_CH);
  assign hit    = ch_hit || (wr_addr == GP_ADDR) || (wr_addr == STEP_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q   <= GP_RST;
      step_q <= STEP_RST;
    end else if (wr_en) begin
      if (wr_addr == GP_ADDR)   gp_q   <= wr_data;
      if (wr_addr == STEP_ADDR) step_q <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
      logic              en;
      logic [BYTE_W-1:0] q;
      assign en = wr_en && ch_hit && (32'(grp) == c) && (sel.idx == field_e'(f));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= field_reset(field_e'(f));
        else if (en) q <= wr_data;
      end
      assign ch_cfg[(c*N_FIELDS+f)*BYTE_W +: BYTE_W] = q;
    end
  end

  assert_unmapped_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> ($stable(gp_q) && $stable(step_q) && $stable(ch_cfg)));
  assert_gp_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == GP_ADDR) |=> (gp_q == $past(wr_data)));
  assert_reset_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gp_q == GP_RST && step_q == STEP_RST));
endmodule

// File: rtl/ledctl_i2c_regs.sv
module ledctl_i2c_regs
  import ledctl_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  DEV_ADDR_LO = 7'h18,
  parameter logic [6:0]  DEV_ADDR_HI = 7'h67,
  localparam int unsigned CFG_W      = NUM_CH * N_FIELDS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              addr_sel,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic [BYTE_W-1:0] gp_q,
  output logic [BYTE_W-1:0] step_q,
  output logic [CFG_W-1:0]  ch_cfg
);
  logic              arst_n, rst_sync_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data;

  assign arst_n = rst_n & hw_en;

  ledctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(arst_n), .rst_sync_n(rst_sync_n)
  );

  ledctl_bus_sync #(.STAGES(SYNC_STAGES)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ledctl_i2c_rx #(.DEV_ADDR_LO(DEV_ADDR_LO), .DEV_ADDR_HI(DEV_ADDR_HI)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .addr_sel(addr_sel),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_low(sda_pull_low),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ledctl_regfile #(.NUM_CH(NUM_CH)) u_regfile (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gp_q(gp_q), .step_q(step_q), .ch_cfg(ch_cfg)
  );
endmodule

// File: tb/ledctl_i2c_regs_bench.sv
`timescale 1ns/1ps
module ledctl_i2c_regs_bench;
  localparam int NUM_CH = 3;
  localparam int CFG_W  = NUM_CH * 7 * 8;
  localparam int Q = 32;   // quarter SCL period, ns
  localparam int H = 64;   // half SCL period, ns
  localparam int NV = 14;
  // {addr_sel, dev7, rw, reg, data, expected ack}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 7'h18, 1'b0, 8'h10, 8'h3F, 1'b1},
    {1'b0, 7'h18, 1'b0, 8'h20, 8'h05, 1'b1},
    {1'b0, 7'h18, 1'b0, 8'hA9, 8'h1F, 1'b1},
    {1'b0, 7'h18, 1'b0, 8'hB5, 8'h77, 1'b1},
    {1'b0, 7'h18, 1'b0, 8'hC2, 8'hAA, 1'b1},
    {1'b0, 7'h67, 1'b0, 8'h10, 8'h00, 1'b0},
    {1'b1, 7'h67, 1'b0, 8'hC9, 8'h11, 1'b1},
    {1'b1, 7'h18, 1'b0, 8'hA1, 8'h22, 1'b0},
    {1'b1, 7'h67, 1'b1, 8'hA3, 8'h44, 1'b0},
    {1'b1, 7'h67, 1'b0, 8'hA7, 8'h99, 1'b1},
    {1'b1, 7'h67, 1'b0, 8'h30, 8'h5C, 1'b1},
    {1'b1, 7'h67, 1'b0, 8'hD9, 8'h66, 1'b1},
    {1'b0, 7'h18, 1'b0, 8'hA5, 8'hC3, 1'b1},
    {1'b0, 7'h19, 1'b0, 8'h10, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n, hw_en, addr_sel, scl_m, sda_m;
  logic sda_pull_low;
  logic [7:0] gp_q, step_q;
  logic [CFG_W-1:0] ch_cfg;
  wire sda_line = sda_m & ~sda_pull_low;

  always #2 clk = ~clk;

  ledctl_i2c_regs u_ledctl_i2c_regs (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .addr_sel(addr_sel),
    .scl_in(scl_m), .sda_in(sda_line), .sda_pull_low(sda_pull_low),
    .gp_q(gp_q), .step_q(step_q), .ch_cfg(ch_cfg)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] model [256];

  function automatic bit mapped(input logic [7:0] a);
    logic [3:0] hi = a[7:4], lo = a[3:0];
    if (a == 8'h10 || a == 8'h20) return 1'b1;
    if (hi < 4'hA || hi > 4'hC) return 1'b0;
    return lo == 4'h9 || lo == 4'h8 || lo == 4'h1 || lo == 4'h5 ||
           lo == 4'h3 || lo == 4'h4 || lo == 4'h2;
  endfunction

  function automatic logic [7:0] dflt(input logic [7:0] a);
    if (a == 8'h20) return 8'h88;
    if (mapped(a) && a != 8'h10 && (a[3:0] == 4'h9 || a[3:0] == 4'h8)) return 8'hE0;
    return 8'h00;
  endfunction

  function automatic logic [7:0] dut_reg(input logic [7:0] a);
    int c, k;
    if (a == 8'h10) return gp_q;
    if (a == 8'h20) return step_q;
    c = int'(a[7:4]) - 10;
    case (a[3:0])
      4'h9: k = 0; 4'h8: k = 1; 4'h1: k = 2; 4'h5: k = 3;
      4'h3: k = 4; 4'h4: k = 5; default: k = 6;
    endcase
    return ch_cfg[(c*7+k)*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit bad = 1'b0;
    n_tests++;
    for (int a = 0; a < 256; a++) begin
      if (mapped(8'(a)) && dut_reg(8'(a)) !== model[a]) begin
        bad = 1'b1;
        $display("FAIL %s reg 0x%02h actual=0x%02h expected=0x%02h", req, a, dut_reg(8'(a)), model[a]);
      end
    end
    if (bad) n_fail++;
  endtask

  task automatic model_reset();
    for (int a = 0; a < 256; a++) model[a] = dflt(8'(a));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #H; sda_m = 1'b0; #H; scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #Q; sda_m = 1'b0; #Q; scl_m = 1'b1; #H; sda_m = 1'b1; #H;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      #Q; sda_m = b[i]; #Q; scl_m = 1'b1; #H; scl_m = 1'b0;
    end
    #Q; sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; ack = ~sda_line; #Q; scl_m = 1'b0;
  endtask

  task automatic write_frame(input logic [6:0] dev, input bit rw, input logic [7:0] ra,
                             input logic [7:0] d, output bit a0, output bit a1, output bit a2);
    bus_start();
    send_byte({dev, rw}, a0);
    send_byte(ra, a1);
    send_byte(d, a2);
    bus_stop();
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit a0, a1, a2, a3;
    bit sel, rw, eack;
    logic [6:0] dev;
    logic [7:0] ra, dat;
    rst_n = 1'b0; hw_en = 1'b1; addr_sel = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    model_reset();
    #41; rst_n = 1'b1; #40;
    // R6 R8: power-on defaults on every mapped register
    check_all("R6 reset defaults");
    check(sda_pull_low == 1'b0, "R3 idle release", 32'(sda_pull_low), 0);

    for (int i = 0; i < NV; i++) begin
      {sel, dev, rw, ra, dat, eack} = VEC[i];
      addr_sel = sel; #20;
      write_frame(dev, rw, ra, dat, a0, a1, a2);
      // R1 R4: address match and direction bit decide the device acknowledge
      check(a0 == eack, "R1/R4 device ack", 32'(a0), 32'(eack));
      // R3 R7: register and data bytes acknowledged only in an accepted frame
      check(a1 == eack && a2 == eack, "R3/R7 byte acks", {a1, a2}, {eack, eack});
      if (eack && !rw && mapped(ra)) model[ra] = dat;
      check_all("R5/R6/R7 register contents");
    end

    // R2: repeated START after register byte; only the second frame writes
    addr_sel = 1'b0; #20;
    bus_start();
    send_byte({7'h18, 1'b0}, a0);
    send_byte(8'hA3, a1);
    bus_start();
    send_byte({7'h18, 1'b0}, a0);
    send_byte(8'hA4, a1);
    send_byte(8'h5A, a2);
    bus_stop();
    model[8'hA4] = 8'h5A;
    check(a0 && a1 && a2, "R2 repeated start acks", {a0, a1, a2}, 3'b111);
    check_all("R2 repeated start");

    // R2: STOP after register byte gives no write
    bus_start();
    send_byte({7'h18, 1'b0}, a0);
    send_byte(8'hB1, a1);
    bus_stop();
    check_all("R2 stop mid frame");

    // R5: two data bytes, last one lands in the same register
    bus_start();
    send_byte({7'h18, 1'b0}, a0);
    send_byte(8'hC8, a1);
    send_byte(8'h01, a2);
    send_byte(8'h02, a3);
    bus_stop();
    model[8'hC8] = 8'h02;
    check(a2 && a3, "R5 extra data ack", {a2, a3}, 2'b11);
    check_all("R5 overwrite same register");

    // R8: hw_en low resets asynchronously, with no clock edge in between
    @(negedge clk); #1;
    hw_en = 1'b0; #0.5;
    model_reset();
    check_all("R8 async hw reset");
    #20; hw_en = 1'b1; #40;

    // R8: frame abandoned by hw_en pulse; later data byte neither acked nor stored
    bus_start();
    send_byte({7'h18, 1'b0}, a0);
    send_byte(8'h10, a1);
    hw_en = 1'b0; #20; hw_en = 1'b1; #20;
    send_byte(8'h7E, a2);
    bus_stop();
    check(a2 == 1'b0, "R8 data after reset not acked", 32'(a2), 0);
    check_all("R8 frame abandoned");

    // R8: rst_n has the same effect
    write_frame(7'h18, 1'b0, 8'h20, 8'h03, a0, a1, a2);
    rst_n = 1'b0; #0.5;
    check(step_q == 8'h88, "R8 rst_n default", 32'(step_q), 32'h88);
    #20; rst_n = 1'b1; #40;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule